// File: doc/BRIEF.md
# Sequential 32-bit Integer Multiplier

This block multiplies two 32-bit integers and returns one 32-bit half of the 64-bit product. A two-bit mode chosen at start selects the result. Mode 0 gives the low half, which is the same for signed and unsigned operands. Mode 1 gives the high half with both operands read as two's complement. Mode 3 gives the high half with both operands read as unsigned. Mode 2 is reserved and returns zero. The mixed signed-by-unsigned high product is not provided.

The design is a shift-add engine run by a small state machine. In IDLE, a `valid_i` pulse captures the operands and the mode and moves the machine to RUN. A signed operation is first turned into unsigned magnitudes plus a single sign flag. RUN takes one partial-product step per cycle for WIDTH cycles. The RUN→FINISH transition fires after the last step. In FINISH the product is negated if the sign flag is set, the chosen half is registered, and `done_o` pulses. FINISH→IDLE is unconditional. `valid_i` has no effect outside IDLE.

Top module: `mul32_unit`

## Requirements
- R1: With mode 0, `result_o` at `done_o` equals the low 32 bits of the product (for example, 25252566 × 5225225 gives 353909638).
- R2: With mode 1, `result_o` at `done_o` equals bits 63..32 of the signed 64-bit product (for example, -1 × -1 gives 0, and 0x80000000 × 0x80000000 gives 0x40000000).
- R3: With mode 3, `result_o` at `done_o` equals bits 63..32 of the unsigned product (for example, 0xFFFFFFFF × 0xFFFFFFFF gives 0xFFFFFFFE).
- R4: With the reserved mode 2, `result_o` at `done_o` is 0.
- R5: `done_o` is high for exactly one cycle. It rises on the 33rd rising edge after the edge that accepted `valid_i` (WIDTH+1 edges).
- R6: A `valid_i` pulse while an operation is in progress (RUN or FINISH) is ignored. The pending result still belongs to the first operands.
- R7: `result_o` changes only on the edge where `done_o` rises. It holds its value at all other times.
- R8: After reset, `done_o` is 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Start strobe, sampled in IDLE |
| mode_i | input | 2 | 0 low half, 1 signed high, 2 reserved, 3 unsigned high |
| op_a_i | input | 32 | Multiplicand |
| op_b_i | input | 32 | Multiplier |
| result_o | output | 32 | Selected product half |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The hardest cases to reach from the ports are a start pulse that arrives mid-operation and the signed magnitude corner at 0x80000000. Each has only a small window or a single operand value. The stimulus therefore pulses `valid_i`, with different operands and mode, a few cycles into RUN. It also places 0x80000000, 0xFFFFFFFF and 0 into a corner pool. Random operations draw from that pool about a third of the time and are otherwise fully random. Between operations the bench idles for a random number of cycles and checks that the result has not moved.

// File: rtl/mul32_pkg.sv
package mul32_pkg;

    typedef enum logic [1:0] {
        MD_LOW    = 2'd0,
        MD_HI_SS  = 2'd1,
        MD_RSVD   = 2'd2,
        MD_HI_UU  = 2'd3
    } mul_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } mul_state_e;

endpackage

// File: rtl/mul32_prep.sv
module mul32_prep #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             signed_i,
    output logic [WIDTH-1:0] mag_a_o,
    output logic [WIDTH-1:0] mag_b_o,
    output logic             neg_o
);
    logic a_neg;
    logic b_neg;

    // A negative value at the most negative code maps to 2^(WIDTH-1), which
    // still fits the unsigned magnitude field.
    assign a_neg   = signed_i & a_i[WIDTH-1];
    assign b_neg   = signed_i & b_i[WIDTH-1];
    assign mag_a_o = a_neg ? (~a_i + 1'b1) : a_i;
    assign mag_b_o = b_neg ? (~b_i + 1'b1) : b_i;
    assign neg_o   = a_neg ^ b_neg;

endmodule

// File: rtl/mul32_engine.sv
module mul32_engine #(
    parameter int WIDTH = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               load_i,
    input  logic               step_i,
    input  logic [WIDTH-1:0]   mcand_i,
    input  logic [WIDTH-1:0]   mplier_i,
    output logic [2*WIDTH-1:0] prod_o
);
    localparam int PW = 2 * WIDTH;

    logic [PW-1:0]  acc_q;
    logic [WIDTH:0] upper_sum;

    always_comb begin
        if (acc_q[0]) begin
            upper_sum = {1'b0, acc_q[PW-1:WIDTH]} + {1'b0, mcand_i};
        end else begin
            upper_sum = {1'b0, acc_q[PW-1:WIDTH]};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q <= '0;
        end else if (load_i) begin
            acc_q <= {{WIDTH{1'b0}}, mplier_i};
        end else if (step_i) begin
            acc_q <= {upper_sum, acc_q[WIDTH-1:1]};
        end
    end

    assign prod_o = acc_q;

endmodule

// File: rtl/mul32_unit.sv
module mul32_unit
    import mul32_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             valid_i,
    input  logic [1:0]       mode_i,
    input  logic [WIDTH-1:0] op_a_i,
    input  logic [WIDTH-1:0] op_b_i,
    output logic [WIDTH-1:0] result_o,
    output logic             done_o
);
    localparam int            PW       = 2 * WIDTH;
    localparam int            CW       = $clog2(WIDTH);
    localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

    mul_state_e       state_q, state_d;
    mul_mode_e        mode_q;
    logic [CW-1:0]    step_cnt_q;
    logic [WIDTH-1:0] mcand_q;
    logic             neg_q;
    logic [WIDTH-1:0] result_q;
    logic             done_q;

    logic             accept;
    logic             is_signed;
    logic [WIDTH-1:0] mag_a, mag_b;
    logic             neg;
    logic [PW-1:0]    prod_mag;
    logic [PW-1:0]    prod_final;
    logic [WIDTH-1:0] result_sel;

    assign accept    = (state_q == ST_IDLE) && valid_i;
    assign is_signed = (mul_mode_e'(mode_i) == MD_HI_SS);

    mul32_prep #(.WIDTH(WIDTH)) u_prep (
        .a_i      (op_a_i),
        .b_i      (op_b_i),
        .signed_i (is_signed),
        .mag_a_o  (mag_a),
        .mag_b_o  (mag_b),
        .neg_o    (neg)
    );

    mul32_engine #(.WIDTH(WIDTH)) u_engine (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (accept),
        .step_i   (state_q == ST_RUN),
        .mcand_i  (mcand_q),
        .mplier_i (mag_b),
        .prod_o   (prod_mag)
    );

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: IDLE->RUN on accept, RUN->FINISH on last step, FINISH->IDLE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (valid_i) state_d = ST_RUN;
            ST_RUN:    if (step_cnt_q == LAST_STEP) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Operand capture and step counting.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mode_q     <= MD_LOW;
            mcand_q    <= '0;
            neg_q      <= 1'b0;
            step_cnt_q <= '0;
        end else if (accept) begin
            mode_q     <= mul_mode_e'(mode_i);
            mcand_q    <= mag_a;
            neg_q      <= neg;
            step_cnt_q <= '0;
        end else if (state_q == ST_RUN) begin
            step_cnt_q <= step_cnt_q + 1'b1;
        end
    end

    assign prod_final = neg_q ? (~prod_mag + 1'b1) : prod_mag;

    always_comb begin
        unique case (mode_q)
            MD_LOW:   result_sel = prod_final[WIDTH-1:0];
            MD_HI_SS: result_sel = prod_final[PW-1:WIDTH];
            MD_HI_UU: result_sel = prod_final[PW-1:WIDTH];
            MD_RSVD:  result_sel = '0;
            default:  result_sel = '0;
        endcase
    end

    // Outputs.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= (state_q == ST_FINISH);
            if (state_q == ST_FINISH) begin
                result_q <= result_sel;
            end
        end
    end

    assign result_o = result_q;
    assign done_o   = done_q;

endmodule

// File: rtl/mul32_unit_chk.sv
module mul32_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             valid_i,
    input logic [1:0]       mode_i,
    input logic [WIDTH-1:0] result_o,
    input logic             done_o
);
    logic        busy_c;
    logic [7:0]  lat_c;
    logic [1:0]  mode_c;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            busy_c <= 1'b0;
            lat_c  <= '0;
            mode_c <= '0;
        end else if (valid_i && (!busy_c || done_o)) begin
            busy_c <= 1'b1;
            lat_c  <= '0;
            mode_c <= mode_i;
        end else if (done_o) begin
            busy_c <= 1'b0;
        end else if (busy_c && lat_c != 8'hFF) begin
            lat_c <= lat_c + 1'b1;
        end
    end

    p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_done_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (busy_c && lat_c == 8'(WIDTH + 1)));

    p_result_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(result_o));

    p_reserved_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && mode_c == 2'd2) |-> result_o == '0);

    p_no_early_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_c |-> !done_o);

endmodule

bind mul32_unit mul32_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .mode_i   (mode_i),
    .result_o (result_o),
    .done_o   (done_o)
);

// File: tb/mul32_unit_tb.sv
`timescale 1ns/1ps
module mul32_unit_tb;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        valid_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [31:0] op_a_i = '0;
    logic [31:0] op_b_i = '0;
    logic [31:0] result_o;
    logic        done_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk_i = ~clk_i;

    mul32_unit u_dut (
        .clk_i, .rst_ni, .valid_i, .mode_i, .op_a_i, .op_b_i, .result_o, .done_o
    );

    function automatic logic [31:0] expect_f(logic [1:0] m, logic [31:0] a, logic [31:0] b);
        logic [63:0] sp, up;
        sp = {{32{a[31]}}, a} * {{32{b[31]}}, b};
        up = {32'b0, a} * {32'b0, b};
        case (m)
            2'd0:    return up[31:0];
            2'd1:    return sp[63:32];
            2'd3:    return up[63:32];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_f(logic [1:0] m);
        case (m)
            2'd0:    return "R1";
            2'd1:    return "R2";
            2'd3:    return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // One operation; optionally pokes valid mid-run with other operands (R6).
    task automatic run_op(logic [1:0] m, logic [31:0] a, logic [31:0] b, bit poke);
        int n;
        @(negedge clk_i);
        valid_i = 1'b1; mode_i = m; op_a_i = a; op_b_i = b;
        @(negedge clk_i);
        valid_i = 1'b0; op_a_i = $urandom; op_b_i = $urandom; mode_i = 2'($urandom);
        n = 1;
        while (!done_o && n < 100) begin
            if (poke && n == 5) valid_i = 1'b1;
            @(negedge clk_i);
            valid_i = 1'b0;
            n++;
        end
        check(poke ? "R6" : tag_f(m), result_o, expect_f(m, a, b));
        check("R5 latency", 32'(n - 1), 32'd33);
        @(negedge clk_i);
        check("R5 single", {31'b0, done_o}, 32'd0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] corners [6];
        logic [31:0] held;
        void'($urandom(32'd20240611));
        corners = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFE};
        repeat (3) @(negedge clk_i);
        check("R8 done", {31'b0, done_o}, 32'd0);
        check("R8 result", result_o, 32'd0);
        rst_ni = 1'b1;

        run_op(2'd0, 32'd25252566, 32'd5225225, 0);        // R1
        run_op(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);     // R2
        run_op(2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);     // R3
        run_op(2'd1, 32'd25252566, 32'd5225225, 0);        // R2
        run_op(2'd3, 32'd25252566, 32'd5225225, 0);        // R3
        run_op(2'd2, 32'hFFFF_FFFF, 32'h1234_5678, 0);     // R4
        run_op(2'd1, 32'h8000_0000, 32'h8000_0000, 0);     // R2
        run_op(2'd1, 32'h8000_0000, 32'h0000_0001, 0);     // R2
        run_op(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);     // R1
        run_op(2'd3, 32'h1234_5678, 32'h9ABC_DEF0, 1);     // R6

        held = result_o;
        repeat (7) @(negedge clk_i);
        check("R7 hold", result_o, held);

        for (int i = 0; i < 300; i++) begin
            logic [1:0]  m;
            logic [31:0] a, b;
            m = 2'($urandom);
            a = ($urandom % 3 == 0) ? corners[$urandom % 6] : $urandom;
            b = ($urandom % 3 == 0) ? corners[$urandom % 6] : $urandom;
            run_op(m, a, b, ($urandom % 8) == 0);
            held = result_o;
            repeat ($urandom % 4) @(negedge clk_i);
            check("R7 hold", result_o, held);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule